// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block sits on the host side of a 12-bit successive-approximation converter that exposes a convert-start line, a busy flag, a serial clock input and a serial data output. On a sample request it drives the start pulse, watches busy until the conversion ends, then clocks out a 16-bit frame with a serial clock divided down from the system clock. The frame is four zero bits followed by the 12-bit result, most significant bit first. It captures each bit on the falling serial clock edge and presents the 12-bit result with a one-cycle valid strobe.

Two power modes are supported. In awake mode the start line idles high and a short low pulse starts each conversion. In auto-sleep mode the start line is held low past the end of conversion, so the converter powers down. The next request raises the line for a wake-up interval and then lowers it again to start the conversion. The controller enforces a guard time between the end of a read and the next start edge. An internal rate timer can issue requests periodically. Requests that arrive while a conversion, read or guard interval is under way are dropped and flagged.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `cnv_o` is 1, `sclk_o` is 0, and `res_vld_o`, `frm_err_o` and `ovr_o` are 0.
- R2: In awake mode a request produces a low pulse on `cnv_o` of exactly START_CYC system clocks, after which `cnv_o` returns high.
- R3: `sclk_o` is low in every cycle in which `cnv_o` falls, and it idles low outside a read.
- R4: No rising edge of `sclk_o` occurs while the converter's busy is high. Each conversion is followed by exactly 16 serial clock pulses (FRAME = LEAD_W + RES_W).
- R5: Each high phase of `sclk_o` lasts exactly HALF_CYC system clocks, and each low phase lasts at least HALF_CYC.
- R6: Bit k of the frame is sampled at the k-th falling edge of `sclk_o`. `res_o` equals frame bits 11..0 (the last 12 bits received, first received = MSB), and `res_vld_o` pulses for one cycle per conversion.
- R7: With CHK_LEAD = 1, `frm_err_o` is 1 together with `res_vld_o` when any of the first four received bits is 1, and 0 otherwise. The result is still delivered.
- R8: At least GUARD_CYC system clocks separate the last falling edge of `sclk_o` from the next falling edge of `cnv_o`.
- R9: In sleep mode (`sleep_mode` = 1), `cnv_o` is low when busy falls and stays low while idle. A request from that state raises `cnv_o` for exactly WAKE_CYC clocks before the start edge.
- R10: A request arriving while the controller is not idle pulses `ovr_o` for one cycle and starts no conversion.
- R11: While `rate_en` is 1, conversions start every RATE_CYC system clocks.
- R12: A request in awake mode issued while `cnv_o` is low (after sleep mode) first raises `cnv_o` for WAKE_CYC clocks, and `cnv_o` idles high after that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_req | input | 1 | One-cycle sample request |
| rate_en | input | 1 | Enables the periodic request timer |
| sleep_mode | input | 1 | 1 selects auto-sleep mode for the next request |
| cnv_o | output | 1 | Convert-start line to the converter |
| busy_i | input | 1 | Converter busy flag (asynchronous) |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| res_o | output | RES_W | Last conversion result |
| res_vld_o | output | 1 | One-cycle strobe for a new result |
| frm_err_o | output | 1 | Leading bits were not all zero (valid with the strobe) |
| ovr_o | output | 1 | One-cycle pulse for a dropped request |

## Verification
The bound checker checks the following on every cycle: the serial clock is low at each start edge, no serial clock rises while busy is high, high-phase width, pulse count per frame, guard spacing, and the single-cycle shape of the valid and overrun strobes. Only the bench scenarios can show that the captured value matches what the converter sent, that leading-bit errors are flagged, that a dropped request really starts nothing, and the wake interval on mode changes. They also show that the start line stays low through busy in sleep mode and the exact period of the rate timer.

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int RES_W     = 12,
  parameter int LEAD_W    = 4,
  parameter int HALF_CYC  = 7,
  parameter int START_CYC = 6,
  parameter int WAKE_CYC  = 750,
  parameter int GUARD_CYC = 50,
  parameter int RATE_CYC  = 1250,
  parameter bit CHK_LEAD  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_req,
  input  logic             rate_en,
  input  logic             sleep_mode,
  output logic             cnv_o,
  input  logic             busy_i,
  output logic             sclk_o,
  input  logic             sdata_i,
  output logic [RES_W-1:0] res_o,
  output logic             res_vld_o,
  output logic             frm_err_o,
  output logic             ovr_o
);
  localparam int FRAME = RES_W + LEAD_W;
  localparam int BW    = $clog2(FRAME + 1);
  localparam int PW    = $clog2(HALF_CYC + 1);
  localparam int RW    = $clog2(RATE_CYC + 1);
  localparam int MX1   = (START_CYC > WAKE_CYC) ? START_CYC : WAKE_CYC;
  localparam int MXT   = (MX1 > GUARD_CYC) ? MX1 : GUARD_CYC;
  localparam int TW    = $clog2(MXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_START, S_WAITB, S_READ, S_GUARD} st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   ph;
  logic [BW-1:0]   bcnt;
  logic [FRAME-1:0] sh;
  logic [2:0]      bsy_sy;
  logic [RW-1:0]   rcnt;
  logic            sclk_q, slp_q;

  wire tick     = rate_en && (rcnt == RW'(RATE_CYC - 1));
  wire req      = smp_req | tick;
  wire bsy_fell = bsy_sy[2] & ~bsy_sy[1];
  wire last_ph  = (ph == PW'(HALF_CYC - 1));
  wire [FRAME-1:0] sh_nx = {sh[FRAME-2:0], sdata_i};

  assign sclk_o = sclk_q;
  assign cnv_o  = slp_q ? (st == S_WAKE) : (st != S_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt   <= '0;
      bsy_sy <= '0;
    end else begin
      rcnt   <= (!rate_en || tick) ? '0 : rcnt + 1'b1;
      bsy_sy <= {bsy_sy[1:0], busy_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      ph        <= '0;
      bcnt      <= '0;
      sh        <= '0;
      sclk_q    <= 1'b0;
      slp_q     <= 1'b0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      ovr_o     <= req && (st != S_IDLE);
      case (st)
        S_IDLE: if (req) begin
          slp_q <= sleep_mode;
          tmr   <= '0;
          st    <= (slp_q || sleep_mode) ? S_WAKE : S_START;
        end
        S_WAKE: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(WAKE_CYC - 1)) begin
            tmr <= '0;
            st  <= S_START;
          end
        end
        S_START: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(START_CYC - 1)) st <= S_WAITB;
        end
        S_WAITB: if (bsy_fell) begin
          ph   <= '0;
          bcnt <= '0;
          st   <= S_READ;
        end
        S_READ: begin
          ph <= last_ph ? '0 : ph + 1'b1;
          if (last_ph) begin
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              sh   <= sh_nx;
              bcnt <= bcnt + 1'b1;
              if (bcnt == BW'(FRAME - 1)) begin
                res_o     <= sh_nx[RES_W-1:0];
                res_vld_o <= 1'b1;
                frm_err_o <= CHK_LEAD && (|sh_nx[FRAME-1 -: LEAD_W]);
                tmr       <= '0;
                st        <= S_GUARD;
              end
            end
          end
        end
        S_GUARD: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(GUARD_CYC - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_rd_chk #(
  parameter int HALF_CYC  = 7,
  parameter int GUARD_CYC = 50,
  parameter int FRAME     = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic busy_i,
  input logic sclk_o,
  input logic res_vld_o,
  input logic ovr_o
);
  logic [15:0] run, gap;
  logic [7:0]  pc;
  logic        sp, cp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      gap <= 16'(GUARD_CYC);
      pc  <= '0;
      sp  <= 1'b0;
      cp  <= 1'b1;
    end else begin
      sp  <= sclk_o;
      cp  <= cnv_o;
      run <= (sclk_o != sp) ? '0 : ((run == 16'hFFFF) ? run : run + 1'b1);
      if (sp && !sclk_o) gap <= '0;
      else if (gap < 16'(GUARD_CYC)) gap <= gap + 1'b1;
      if (cp && !cnv_o) pc <= '0;
      else if (!sp && sclk_o && pc != 8'hFF) pc <= pc + 1'b1;
    end
  end

  AST_SCLK_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> !sclk_o); // R3
  AST_NO_SCLK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !busy_i); // R4
  AST_PULSES_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> pc < 8'(FRAME)); // R4
  AST_FULL_FRAME_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> pc == 8'(FRAME)); // R4
  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> run == 16'(HALF_CYC - 1)); // R5
  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> run >= 16'(HALF_CYC - 1)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o); // R6
  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> gap >= 16'(GUARD_CYC)); // R8
  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> !ovr_o); // R10
endmodule

bind adc_rd_ctrl adc_rd_chk #(
  .HALF_CYC(HALF_CYC), .GUARD_CYC(GUARD_CYC), .FRAME(RES_W + LEAD_W)
) u_adc_rd_chk (
  .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .busy_i(busy_i),
  .sclk_o(sclk_o), .res_vld_o(res_vld_o), .ovr_o(ovr_o)
);

// File: tb/test_adc_rd_ctrl.sv
module test_adc_rd_ctrl;
  localparam int HALF  = 7;
  localparam int START = 6;
  localparam int WAKE  = 40;
  localparam int GUARD = 50;
  localparam int RATE  = 400;
  localparam int CONV  = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_req = 1'b0, rate_en = 1'b0, sleep_mode = 1'b0;
  logic cnv, busy, sclk, sdata, vld, frm, ovr;
  logic [11:0] res;

  always #4 clk = ~clk;

  adc_rd_ctrl #(.HALF_CYC(HALF), .START_CYC(START), .WAKE_CYC(WAKE),
                .GUARD_CYC(GUARD), .RATE_CYC(RATE)) i_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .rate_en(rate_en),
    .sleep_mode(sleep_mode), .cnv_o(cnv), .busy_i(busy), .sclk_o(sclk),
    .sdata_i(sdata), .res_o(res), .res_vld_o(vld), .frm_err_o(frm), .ovr_o(ovr));

  int nchk = 0, nfail = 0;
  bit done = 0;
  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model and cycle monitor
  logic [3:0]  dev_lead = 4'h0;
  logic [11:0] dev_code = 12'h000;
  logic [15:0] cur_frame = '0;
  logic [15:0] expq[$];
  int bidx = 16, conv_left = 0, pulses = 0, gap = 1000, ncnv = 0, vld_cnt = 0, ovr_cnt = 0;
  int cnv_run = 0, sclk_run = 0, cyc = 0, last_fall = -1;
  bit cnv_p = 1, sclk_p = 0, have_read = 0;
  bit chk_start = 0, chk_wake = 0, chk_sleep = 0, chk_rate = 0;
  logic dev_busy = 1'b0;
  assign busy  = dev_busy;
  assign sdata = (bidx < 16) ? cur_frame[15 - bidx] : 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cnv_p = cnv; sclk_p = sclk; cnv_run = 1; sclk_run = 1;
    end else begin
      cyc++;
      if (dev_busy) begin
        conv_left--;
        if (conv_left == 0) begin
          dev_busy = 1'b0;
          if (chk_sleep) check(!cnv, "R9 start line low at busy fall", cnv, 0);
        end
      end
      if (!sclk_p && sclk) check(!dev_busy, "R4 sclk rise while busy", dev_busy, 0);
      if (sclk_p && !sclk) begin
        check(sclk_run == HALF, "R5 sclk high phase", sclk_run, HALF);
        bidx++; pulses++; gap = 0;
      end else gap++;
      if (vld) begin
        logic [15:0] f;
        f = (expq.size() > 0) ? expq.pop_front() : 16'hxxxx;
        check(res == f[11:0], "R6 result", res, f[11:0]);
        check(frm == (|f[15:12]), "R7 frame error flag", frm, |f[15:12]);
        check(pulses == 16, "R4 pulses per read", pulses, 16);
        vld_cnt++; have_read = 1;
      end
      if (ovr) ovr_cnt++;
      if (cnv_p && !cnv) begin
        check(!sclk, "R3 sclk low at start edge", sclk, 0);
        if (have_read) begin
          check(gap >= GUARD, "R8 guard before start", gap, GUARD);
          check(pulses == 16, "R4 pulses before next start", pulses, 16);
        end
        if (chk_wake) check(cnv_run == WAKE, "R9/R12 wake interval", cnv_run, WAKE);
        if (chk_rate && last_fall >= 0) check(cyc - last_fall == RATE, "R11 rate period", cyc - last_fall, RATE);
        last_fall = cyc;
        ncnv++; pulses = 0; bidx = 0;
        cur_frame = {dev_lead, dev_code};
        expq.push_back(cur_frame);
        dev_busy = 1'b1; conv_left = CONV;
      end
      if (!cnv_p && cnv && chk_start) check(cnv_run == START, "R2 start pulse width", cnv_run, START);
      cnv_run  = (cnv == cnv_p) ? cnv_run + 1 : 1;
      sclk_run = (sclk == sclk_p) ? sclk_run + 1 : 1;
      cnv_p = cnv; sclk_p = sclk;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_req();
    @(negedge clk); #1 smp_req = 1'b1;
    @(negedge clk); #1 smp_req = 1'b0;
  endtask

  task automatic convert(logic [3:0] lead, logic [11:0] code);
    int v0, t;
    dev_lead = lead; dev_code = code;
    v0 = vld_cnt;
    pulse_req();
    t = 0;
    while (vld_cnt == v0 && t < 5000) begin tick(1); t++; end
    check(vld_cnt == v0 + 1, "R6 result strobe arrives", vld_cnt - v0, 1);
    tick(GUARD + 10);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int n0, o0, v0;
    tick(3);
    check(cnv == 1 && sclk == 0, "R1 lines in reset", {cnv, sclk}, 2);
    check(!vld && !frm && !ovr, "R1 flags in reset", {vld, frm, ovr}, 0);
    rst_n = 1'b1;
    tick(2);
    check(cnv == 1 && sclk == 0 && !vld && !ovr, "R1 after reset", {cnv, sclk, vld, ovr}, 8);

    chk_start = 1;
    convert(4'h0, 12'hABC);
    convert(4'h0, 12'h000);
    convert(4'h0, 12'hFFF);
    convert(4'h0, 12'h555);
    convert(4'b0100, 12'h123);
    convert(4'h0, 12'h801);
    check(sclk == 0, "R3 sclk idles low", sclk, 0);

    // overrun: second request while the first is in progress
    n0 = ncnv; o0 = ovr_cnt; v0 = vld_cnt;
    dev_code = 12'h7E1;
    pulse_req();
    tick(10);
    pulse_req();
    check(ovr_cnt == o0 + 1, "R10 overrun flagged", ovr_cnt - o0, 1);
    tick(700);
    check(ncnv == n0 + 1, "R10 dropped request starts nothing", ncnv - n0, 1);
    check(vld_cnt == v0 + 1, "R10 one result only", vld_cnt - v0, 1);

    // auto-sleep mode
    chk_start = 0; chk_sleep = 1;
    sleep_mode = 1'b1;
    convert(4'h0, 12'h3A5);
    check(cnv == 0, "R9 start line low when idle", cnv, 0);
    chk_wake = 1;
    convert(4'h0, 12'hC3C);
    check(cnv == 0, "R9 start line stays low", cnv, 0);
    chk_sleep = 0;

    // back to awake mode from a low start line
    sleep_mode = 1'b0;
    convert(4'h0, 12'h0F0);
    chk_wake = 0;
    check(cnv == 1, "R12 start line idles high again", cnv, 1);

    // periodic timer
    chk_start = 1; chk_rate = 1; last_fall = -1;
    dev_code = 12'h3C5;
    v0 = vld_cnt;
    tick(1); rate_en = 1'b1;
    tick(5 * RATE + 20);
    rate_en = 1'b0;
    tick(700);
    chk_rate = 0;
    check(vld_cnt - v0 == 5, "R11 conversions per window", vld_cnt - v0, 5);
    check(expq.size() == 0, "R6 every start yields a result", expq.size(), 0);
    finish_up();
  end
endmodule